// File: doc/BRIEF.md
# Four-Slot TDM PCM Serial Port

This block connects a four-channel voice codec to a time-division PCM highway. Everything runs from one bit clock, nominally 2048 kHz, and one frame strobe at 8 kHz, which gives 256 bit periods per frame. A frame starts on the rising clock edge where the strobe is first seen high. On transmit, the block sends the four 8-bit companded samples one after another on a serial line, most significant bit first. Each bit is launched on a rising edge, and an output enable marks when the line is being driven. After the 32nd bit the line is released until the next frame.

On receive, the block takes 32 bits from the serial input on the falling edges that follow the frame start. The bits form four 8-bit slots for channels 1 to 4. When the 32nd bit arrives, all four received bytes are updated at the same time and a one-period done pulse is raised. Each channel has an effective power state, which is the OR of a pin bit and a register bit. A channel that is powered down leaves the line undriven during its own transmit slot.

Transmit samples are copied into a shadow register at frame start, so changes to the inputs during a frame do not affect that frame. A new strobe edge that arrives partway through a frame discards the frame in progress and restarts from channel 1.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame, `sd_oe` and `rx_done` are 0 and `rx_samples` is all zeros.
- R2: A frame starts at the rising edge where `fsync` is sampled 1 and was sampled 0 at the previous rising edge. On that same edge, `sd_out` carries bit 7 of channel 1 (`tx_samples[7]`) and `sd_oe` takes channel 1's effective power state.
- R3: Channel n occupies port bits [8n-1:8n-8] of `tx_samples`. Its bits go out MSB first, on rising edges 8(n-1)+1 to 8n counted from the start edge as edge 1.
- R4: On rising edge 33 `sd_oe` drops to 0, and it stays 0 until the next frame start.
- R5: The effective power state of channel n is `pwr_pin[n-1] | pwr_reg[n-1]`, where 1 means up. When it is 0, `sd_oe` is 0 for all eight edges of that channel's slot.
- R6: `tx_samples` is captured at the start edge. Changes to it later in the frame do not alter the bits sent in that frame.
- R7: Receive bit k (k = 1..32) is the value of `sd_in` at the k-th falling edge after the start edge. Bits 1..32 fill channels 1..4, MSB first. The byte for channel n appears at `rx_samples[8n-1:8n-8]`. `rx_done` is 1 for exactly one clock period, starting at the 32nd falling edge, and all four bytes change at that same edge. Bits after the 32nd are ignored.
- R8: A frame start that arrives before the current frame has finished abandons it. Transmit restarts from channel 1, and receive starts a fresh 32-bit count with no done pulse for the abandoned frame.
- R9: If `fsync` is held high over several rising edges, only one frame starts.
- R10: Between done pulses, `rx_samples` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; transmit on rising edges, receive on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| fsync | input | 1 | Frame strobe, sampled on rising edges |
| tx_samples | input | 32 | Four transmit samples; channel n at bits [8n-1:8n-8] |
| pwr_pin | input | 4 | Pin power-up bits, bit n-1 for channel n |
| pwr_reg | input | 4 | Register power-up bits, bit n-1 for channel n |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| sd_oe | output | 1 | High while `sd_out` is driven |
| rx_samples | output | 32 | Four received samples; channel n at bits [8n-1:8n-8] |
| rx_done | output | 1 | One-period pulse when a full receive frame has been taken |

## Verification
The bench checks every transmit edge of several frames, each with a different power mix. It checks that the line is released on edge 33. A design that is off by one there would either drive a stray 33rd bit or lose the last bit of channel 4. It also checks that a powered-down channel leaves exactly its own eight edges undriven, and that changing the transmit samples mid-frame has no effect. A design that read its inputs live would leak the new values into the frame in flight. On receive, the bench checks that bytes appear only after the 32nd falling edge and stay put through trailing bits. A strobe arriving mid-frame must restart the slot count, and one held high for several edges must give a single start. Either mistake would shift every slot.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  parameter int unsigned DEF_CHANNELS = 4;
  parameter int unsigned DEF_SAMPLE_W = 8;

  function automatic int unsigned frame_bits(input int unsigned ch, input int unsigned w);
    return ch * w;
  endfunction
endpackage

// File: rtl/pcm_tdm_frame_ctrl.sv
module pcm_tdm_frame_ctrl #(
  parameter int unsigned FRAME_BITS = 32,
  parameter int unsigned CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             start,
  output logic             frame_q,
  output logic             active,
  output logic [CNT_W-1:0] cnt
);
  logic             fs_q;
  logic             active_q, active_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb start = fsync & ~fs_q;

  always_comb begin
    active_n = active_q;
    cnt_n    = cnt_q;
    if (start) begin
      active_n = 1'b1;
      cnt_n    = CNT_W'(1);
    end else if (active_q) begin
      if (cnt_q == CNT_W'(FRAME_BITS)) begin
        active_n = 1'b0;
        cnt_n    = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      frame_q  <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      fs_q     <= fsync;
      frame_q  <= start;
      active_q <= active_n;
      cnt_q    <= cnt_n;
    end
  end

  assign active = active_q;
  assign cnt    = cnt_q;

  // R8: any accepted start restarts the bit count at one
  p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == CNT_W'(1) && active_q));

  // R9: a strobe held high yields a single start
  p_single_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fsync) |=> (fsync |-> !start));
endmodule

// File: rtl/pcm_tdm_tx.sv
module pcm_tdm_tx #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned FRAME_BITS = NUM_CH * SAMPLE_W,
  parameter int unsigned CNT_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  active,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [FRAME_BITS-1:0] tx_flat,
  input  logic [NUM_CH-1:0]     pwr_eff,
  output logic                  sd,
  output logic                  oe
);
  logic [FRAME_BITS-1:0] ordered;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic                  sh_en;
  logic                  sd_q, sd_n, oe_q, oe_n;
  logic                  slot_pwr;

  // channel 1 goes to the top of the serial word
  always_comb begin
    ordered = '0;
    for (int c = 0; c < NUM_CH; c++)
      ordered[FRAME_BITS-1-c*SAMPLE_W -: SAMPLE_W] = tx_flat[c*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    slot_pwr = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if ((int'(cnt) / int'(SAMPLE_W)) == c) slot_pwr = pwr_eff[c];
  end

  always_comb begin
    sh_n  = sh_q;
    sh_en = 1'b0;
    sd_n  = 1'b0;
    oe_n  = 1'b0;
    if (start) begin
      sh_en = 1'b1;
      sh_n  = {ordered[FRAME_BITS-2:0], 1'b0};
      sd_n  = ordered[FRAME_BITS-1];
      oe_n  = pwr_eff[0];
    end else if (active && (cnt < CNT_W'(FRAME_BITS))) begin
      sh_en = 1'b1;
      sh_n  = {sh_q[FRAME_BITS-2:0], 1'b0};
      sd_n  = sh_q[FRAME_BITS-1];
      oe_n  = slot_pwr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      if (sh_en) sh_q <= sh_n;
      sd_q <= sd_n;
      oe_q <= oe_n;
    end
  end

  assign sd = sd_q;
  assign oe = oe_q;

  // R2: the start edge launches channel 1 MSB
  p_start_ch1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sd_q == $past(tx_flat[SAMPLE_W-1]) && oe_q == $past(pwr_eff[0])));

  // R4: bus released after the last slot and while idle
  p_bus_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (!active || cnt == CNT_W'(FRAME_BITS))) |=> !oe_q);

  // R5: a powered-down channel never drives its slot
  for (genvar c = 0; c < NUM_CH; c++) begin : g_pd
    p_pd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && active && ((int'(cnt) / int'(SAMPLE_W)) == c) && !pwr_eff[c]) |=> !oe_q);
  end
endmodule

// File: rtl/pcm_tdm_rx.sv
module pcm_tdm_rx #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned SAMPLE_W   = 8,
  parameter int unsigned FRAME_BITS = NUM_CH * SAMPLE_W,
  parameter int unsigned CNT_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_q,
  input  logic                  sd_in,
  output logic [FRAME_BITS-1:0] rx_flat,
  output logic                  done
);
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [FRAME_BITS-1:0] out_q, out_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic                  act_q, act_n;
  logic                  done_q, done_n;
  logic                  sh_en, out_en;

  always_comb begin
    sh_n   = {sh_q[FRAME_BITS-2:0], sd_in};
    sh_en  = 1'b0;
    out_en = 1'b0;
    cnt_n  = cnt_q;
    act_n  = act_q;
    done_n = 1'b0;
    if (frame_q) begin
      sh_en = 1'b1;
      cnt_n = CNT_W'(1);
      act_n = 1'b1;
    end else if (act_q) begin
      sh_en = 1'b1;
      if (cnt_q == CNT_W'(FRAME_BITS-1)) begin
        out_en = 1'b1;
        done_n = 1'b1;
        act_n  = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  // first received bit is channel 1 MSB
  always_comb begin
    out_n = '0;
    for (int c = 0; c < NUM_CH; c++)
      out_n[c*SAMPLE_W +: SAMPLE_W] = sh_n[FRAME_BITS-1-c*SAMPLE_W -: SAMPLE_W];
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      out_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (sh_en)  sh_q  <= sh_n;
      if (out_en) out_q <= out_n;
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      done_q <= done_n;
    end
  end

  assign rx_flat = out_q;
  assign done    = done_q;

  // R7: done lasts one period
  p_done_single_r7: assert property (@(negedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: received bytes move only with a done pulse
  p_rx_hold_r10: assert property (@(negedge clk) disable iff (!rst_n)
    !done_q |-> $stable(out_q));
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int unsigned NUM_CH   = DEF_CHANNELS,
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic                         clk_bit,
  input  logic                         rst_n,
  input  logic                         fsync,
  input  logic [NUM_CH*SAMPLE_W-1:0]   tx_samples,
  input  logic [NUM_CH-1:0]            pwr_pin,
  input  logic [NUM_CH-1:0]            pwr_reg,
  input  logic                         sd_in,
  output logic                         sd_out,
  output logic                         sd_oe,
  output logic [NUM_CH*SAMPLE_W-1:0]   rx_samples,
  output logic                         rx_done
);
  localparam int unsigned FRAME_BITS = frame_bits(NUM_CH, SAMPLE_W);
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  logic             rst_m_q, rst_core;
  logic             start, frame_q, active;
  logic [CNT_W-1:0] cnt;
  logic [NUM_CH-1:0] pwr_eff;

  // asynchronous assert, release aligned to the bit clock
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q  <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_m_q  <= 1'b1;
      rst_core <= rst_m_q;
    end
  end

  always_comb pwr_eff = pwr_pin | pwr_reg;

  pcm_tdm_frame_ctrl #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk_bit), .rst_n(rst_core), .fsync(fsync),
    .start(start), .frame_q(frame_q), .active(active), .cnt(cnt)
  );

  pcm_tdm_tx #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_tx (
    .clk(clk_bit), .rst_n(rst_core), .start(start), .active(active), .cnt(cnt),
    .tx_flat(tx_samples), .pwr_eff(pwr_eff), .sd(sd_out), .oe(sd_oe)
  );

  pcm_tdm_rx #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_rx (
    .clk(clk_bit), .rst_n(rst_core), .frame_q(frame_q), .sd_in(sd_in),
    .rx_flat(rx_samples), .done(rx_done)
  );
endmodule

// File: tb/sim_pcm_tdm_port.sv
module sim_pcm_tdm_port;
  logic        clk_bit = 1'b0;
  logic        rst_n;
  logic        fsync;
  logic [31:0] tx_samples;
  logic [3:0]  pwr_pin, pwr_reg;
  logic        sd_in;
  logic        sd_out, sd_oe;
  logic [31:0] rx_samples;
  logic        rx_done;

  int n_chk = 0;
  int n_bad = 0;

  // {tx samples, pin bits, reg bits, receive serial stream (first bit at [31])}
  localparam logic [71:0] VEC [0:3] = '{
    {32'h01FF3CA5, 4'hF, 4'h0, 32'h12345678},
    {32'h5AC3807E, 4'h0, 4'h5, 32'hF0E1D2C3},
    {32'hDEADBEEF, 4'h0, 4'h0, 32'h0F0F0F0F},
    {32'h9669A55A, 4'hA, 4'h4, 32'hFFFF0000}
  };

  always #4 clk_bit = ~clk_bit;

  pcm_tdm_port u0 (
    .clk_bit(clk_bit), .rst_n(rst_n), .fsync(fsync), .tx_samples(tx_samples),
    .pwr_pin(pwr_pin), .pwr_reg(pwr_reg), .sd_in(sd_in), .sd_out(sd_out),
    .sd_oe(sd_oe), .rx_samples(rx_samples), .rx_done(rx_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rx_expect(input logic [31:0] stream);
    logic [31:0] r;
    for (int c = 0; c < 4; c++) r[c*8 +: 8] = stream[31-8*c -: 8];
    return r;
  endfunction

  // one full frame from table row idx; fsync held for 'hold' edges
  task automatic run_frame(input int idx, input int hold);
    logic [31:0] tx, rxs, exp_rx, prev_rx;
    logic [3:0]  eff;
    tx  = VEC[idx][71:40];
    eff = VEC[idx][39:36] | VEC[idx][35:32];
    rxs = VEC[idx][31:0];
    exp_rx = rx_expect(rxs);
    @(posedge clk_bit); #1;
    prev_rx    = rx_samples;
    fsync      = 1'b1;
    tx_samples = tx;
    pwr_pin    = VEC[idx][39:36];
    pwr_reg    = VEC[idx][35:32];
    for (int e = 1; e <= 34; e++) begin
      @(posedge clk_bit); #1;
      if (e == hold) fsync = 1'b0;
      if (e == 1) tx_samples = ~tx;            // R6: late change must not leak
      sd_in = (e <= 32) ? rxs[32-e] : ~sd_in;  // R7: trailing bits ignored
      #1;
      if (e <= 32) begin
        int ch = (e - 1) / 8;
        logic expb = tx[ch*8 + 7 - (e-1)%8];
        check(sd_oe === eff[ch], "R5 slot enable", {31'b0, sd_oe}, {31'b0, eff[ch]});
        if (eff[ch])
          check(sd_out === expb, (e == 1) ? "R2 first bit" : "R3/R6 serial bit",
                {31'b0, sd_out}, {31'b0, expb});
        check(rx_done === 1'b0, "R7 no early done", {31'b0, rx_done}, 32'd0);
        check(rx_samples === prev_rx, "R10 hold during frame", rx_samples, prev_rx);
      end else if (e == 33) begin
        check(sd_oe === 1'b0, "R4 release on edge 33", {31'b0, sd_oe}, 32'd0);
        check(rx_done === 1'b1, "R7 done pulse", {31'b0, rx_done}, 32'd1);
        check(rx_samples === exp_rx, "R7 received bytes", rx_samples, exp_rx);
      end else begin
        check(sd_oe === 1'b0, "R4 stays released", {31'b0, sd_oe}, 32'd0);
        check(rx_done === 1'b0, "R7 done one period", {31'b0, rx_done}, 32'd0);
      end
    end
    fsync = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] last;
    rst_n = 1'b0; fsync = 1'b0; sd_in = 1'b0;
    tx_samples = '0; pwr_pin = '0; pwr_reg = '0;
    #21;
    check(sd_oe === 1'b0 && rx_done === 1'b0, "R1 reset outputs", {30'b0, sd_oe, rx_done}, 32'd0);
    check(rx_samples === 32'd0, "R1 reset rx", rx_samples, 32'd0);
    @(posedge clk_bit); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk_bit);
    #2;
    check(sd_oe === 1'b0 && rx_done === 1'b0 && rx_samples === 32'd0, "R1 idle after reset",
          rx_samples, 32'd0);

    for (int i = 0; i < 4; i++) begin
      run_frame(i, 1);
      repeat (3) @(posedge clk_bit);
    end

    // R9: strobe held high over three edges
    run_frame(3, 3);

    // R4: stays released over a long idle stretch
    for (int k = 0; k < 20; k++) begin
      @(posedge clk_bit); #2;
      check(sd_oe === 1'b0, "R4 idle", {31'b0, sd_oe}, 32'd0);
    end

    // R8: abandon a frame after 11 edges, then a full frame restarts from channel 1
    last = rx_samples;
    @(posedge clk_bit); #1;
    fsync = 1'b1; tx_samples = 32'h11223344; pwr_pin = 4'hF; pwr_reg = 4'h0;
    @(posedge clk_bit); #1 fsync = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_bit); #2;
      check(rx_done === 1'b0, "R8 no done for partial frame", {31'b0, rx_done}, 32'd0);
    end
    check(rx_samples === last, "R8 partial frame leaves rx", rx_samples, last);
    run_frame(1, 1);
    run_frame(0, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule